// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts conditional branch direction from two inputs: the low-order bits of the branch address and the outcomes of the most recently resolved branches. A shift register of the last `HIST_W` outcomes is appended to `IDX_W` address bits. The result selects one saturating counter of width `CTR_W` from a table of `2^(IDX_W+HIST_W)` entries. Each address slot therefore holds `2^HIST_W` independent predictors, and the recent global path decides which of them is used.

The lookup port is combinational. A fetch stage presents an address and receives a taken or not-taken guess in the same cycle. It also receives the history value that produced the guess. The pipeline carries that snapshot along with the branch. When the branch resolves, the pipeline returns the address, the snapshot and the real outcome on the update port. The block then trains the counter that made the guess and shifts the outcome into the history.

The table keeps no tags, so branches whose low address bits match share entries. With `HIST_W=1` and `CTR_W=1` the block becomes a two-predictor-per-slot, one-bit scheme.

Top module: `corr_bpred`

## Requirements
- R1: After reset, every counter holds 2^(CTR_W-1)-1, so every lookup predicts not taken, and the history output reads zero.
- R2: On a cycle with `upd_valid_i` high, the history shifts left by one. `upd_taken_i` enters bit 0 and the oldest bit is dropped. The new value appears on `lkp_hist_o` in the following cycle.
- R3: The table index is `{addr[IDX_W-1:0], hist}`, with the address bits in the upper part. Lookups use the current history. Updates use `upd_hist_i`, not the current history.
- R4: A valid update with `upd_taken_i=1` raises the selected counter by one. A counter already at 2^CTR_W-1 stays there.
- R5: A valid update with `upd_taken_i=0` lowers the selected counter by one. A counter already at 0 stays there.
- R6: `lkp_taken_o` is 1 exactly when the selected counter is at least 2^(CTR_W-1).
- R7: Address bits at and above position `IDX_W` are ignored by both ports. Addresses that differ only there share entries.
- R8: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction from the value held before the update.
- R9: While `upd_valid_i` is low, no counter and no history bit changes.
- R10: With `HIST_W=1, CTR_W=1`, each slot holds two one-bit predictions. The previous branch outcome selects between them: a taken branch writes 1 and a not-taken branch writes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_addr_i | input | ADDR_W | Address of the branch being fetched |
| lkp_taken_o | output | 1 | Predicted direction, 1 = taken |
| lkp_hist_o | output | HIST_W | History used for this lookup, carried to the update port |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_hist_i | input | HIST_W | History snapshot taken at lookup time |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong counter value shows at the ports only when that entry is looked up again with the matching history. In the worst case it shows as a single flipped prediction near the threshold, one cycle after the faulty write. A history fault is seen on `lkp_hist_o` in the cycle after the update. It also moves every later lookup to a different column of the table. The bench therefore compares the prediction and the history on every cycle against a reference model. It does this across long random runs with narrow address ranges, so entries are revisited often and corruption is caught within a few cycles.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned top,
                                           input logic inc);
    if (inc) return (cur >= top) ? top : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = bit_i;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], bit_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_o[0] == $past(bit_i));

  generate
    if (HIST_W > 1) begin : g_age_chk
      assert_age_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0]));
    end
  endgenerate

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_o));
endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step
  import corr_bpred_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur_i,
  input  logic             inc_i,
  output logic [CTR_W-1:0] nxt_o
);
  localparam int unsigned TOP = (2 ** CTR_W) - 1;

  always_comb nxt_o = CTR_W'(sat_step(int'(cur_i), TOP, inc_i));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IX_W  = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IX_W-1:0]  rd_idx_i,
  output logic [CTR_W-1:0] rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IX_W-1:0]  wr_idx_i,
  input  logic             wr_inc_i
);
  localparam int DEPTH = 2 ** IX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_RST = CTR_W'((2 ** (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] wr_cur, wr_nxt;

  assign wr_cur = ctr_q[wr_idx_i];

  bp_sat_step #(.CTR_W(CTR_W)) u_step (
    .cur_i (wr_cur),
    .inc_i (wr_inc_i),
    .nxt_o (wr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CTR_RST;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= wr_nxt;
    end
  end

  // read sees the stored value, so a same-cycle write is not forwarded
  assign rd_ctr_o = ctr_q[rd_idx_i];

  assert_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_inc_i && wr_cur != CTR_MAX) |=>
      ctr_q[$past(wr_idx_i)] == $past(wr_cur) + 1'b1);
  assert_sat_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_inc_i && wr_cur == CTR_MAX) |=> ctr_q[$past(wr_idx_i)] == CTR_MAX);
  assert_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_inc_i && wr_cur != '0) |=>
      ctr_q[$past(wr_idx_i)] == $past(wr_cur) - 1'b1);
  assert_sat_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_inc_i && wr_cur == '0) |=> ctr_q[$past(wr_idx_i)] == '0);
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic              lkp_taken_o,
  output logic [HIST_W-1:0] lkp_hist_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  localparam int IX_W = IDX_W + HIST_W;

  logic [HIST_W-1:0] hist;
  logic [IX_W-1:0]   rd_idx, wr_idx;
  logic [CTR_W-1:0]  rd_ctr;

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  assign rd_idx = {lkp_addr_i[IDX_W-1:0], hist};
  assign wr_idx = {upd_addr_i[IDX_W-1:0], upd_hist_i};

  bp_ctr_table #(.IX_W(IX_W), .CTR_W(CTR_W)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_ctr_o (rd_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (wr_idx),
    .wr_inc_i (upd_taken_i)
  );

  assign lkp_taken_o = rd_ctr[CTR_W-1];
  assign lkp_hist_o  = hist;

  assert_hist_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> lkp_hist_o[0] == $past(upd_taken_i));
endmodule

// File: tb/corr_bpred_test.sv
module corr_bpred_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 2;
  localparam int CTR_W  = 2;
  localparam int DEPTH  = 2 ** (IDX_W + HIST_W);
  localparam int CMAX   = (2 ** CTR_W) - 1;
  localparam int HALF   = 2 ** (CTR_W - 1);

  logic clk = 0, rst_ni = 0;
  logic [ADDR_W-1:0] lkp_addr = '0, upd_addr = '0;
  logic [HIST_W-1:0] upd_hist = '0, lkp_hist;
  logic upd_valid = 0, upd_taken = 0, lkp_taken;

  logic [ADDR_W-1:0] a11_lkp = '0, a11_upd = '0;
  logic a11_hin = 0, a11_hout, a11_v = 0, a11_t = 0, a11_pred;

  int checks = 0, fails = 0;
  int m_ctr [DEPTH];
  int m_hist = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  corr_bpred #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_addr_i(lkp_addr), .lkp_taken_o(lkp_taken),
    .lkp_hist_o(lkp_hist), .upd_valid_i(upd_valid), .upd_addr_i(upd_addr),
    .upd_hist_i(upd_hist), .upd_taken_i(upd_taken));

  corr_bpred #(.ADDR_W(ADDR_W), .IDX_W(2), .HIST_W(1), .CTR_W(1)) uut_11 (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_addr_i(a11_lkp), .lkp_taken_o(a11_pred),
    .lkp_hist_o(a11_hout), .upd_valid_i(a11_v), .upd_addr_i(a11_upd),
    .upd_hist_i(a11_hin), .upd_taken_i(a11_t));

  function automatic int idx_of(input logic [ADDR_W-1:0] a, input int h);
    return (int'(a[IDX_W-1:0]) << HIST_W) | (h & ((1 << HIST_W) - 1));
  endfunction

  function automatic int sat(input int v, input bit inc);
    if (inc) return (v == CMAX) ? CMAX : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle on the main instance, check lookup before the edge
  task automatic step(input logic [ADDR_W-1:0] la, input bit uv, input logic [ADDR_W-1:0] ua,
                      input int uh, input bit ut, input string req);
    int e;
    @(negedge clk);
    lkp_addr = la; upd_valid = uv; upd_addr = ua; upd_hist = HIST_W'(uh); upd_taken = ut;
    #1;
    e = (m_ctr[idx_of(la, m_hist)] >= HALF) ? 1 : 0;
    chk(lkp_taken == e[0], req, int'(lkp_taken), e);
    chk(int'(lkp_hist) == m_hist, "R2", int'(lkp_hist), m_hist);
    @(posedge clk);
    if (uv) begin
      e = idx_of(ua, uh);
      m_ctr[e] = sat(m_ctr[e], ut);
      m_hist = ((m_hist << 1) | int'(ut)) & ((1 << HIST_W) - 1);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = HALF - 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;

    // R1: every slot predicts not taken after reset
    for (int a = 0; a < (1 << IDX_W); a++) step(ADDR_W'(a), 0, '0, 0, 0, "R1");
    @(negedge clk); #1;
    chk(lkp_hist == '0, "R1", int'(lkp_hist), 0);
    chk(a11_pred == 1'b0 && a11_hout == 1'b0, "R1", int'(a11_pred), 0);

    // R4/R6: saturate upward on slot 3, history held at 0 via upd_hist
    for (int k = 0; k < 5; k++) step(16'h0003, 1, 16'h0003, 0, 1, "R4");
    // R9: no update, history and table hold
    step(16'h0003, 0, 16'h0003, 0, 0, "R9");
    step(16'h0003, 0, 16'h0003, 0, 0, "R9");
    // R5: saturate downward on slot 5 history 3
    for (int k = 0; k < 6; k++) step(16'h0005, 1, 16'h0005, 3, 0, "R5");
    step(16'h0005, 1, 16'h0005, 3, 1, "R5");
    // R3: updates under history 2 train a different column than current history
    for (int k = 0; k < 3; k++) step(16'h0007, 1, 16'h0007, 2, 1, "R3");
    step(16'h0007, 0, '0, 0, 0, "R3");
    // R7: upper address bits alias
    step(16'hA007, 1, 16'h5007, 2, 1, "R7");
    step(16'hFFF7, 0, '0, 0, 0, "R7");
    // R8: same-cycle hit returns the old value; slot 9 hist = current
    step(16'h0009, 1, 16'h0009, m_hist, 1, "R8");
    step(16'h0009, 1, 16'h0009, m_hist, 1, "R8");

    // random mix with narrow address range so entries are revisited
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] la, ua;
      int uh;
      la = ADDR_W'($urandom);
      ua = ($urandom_range(0, 1) == 1) ? la : ADDR_W'($urandom);
      uh = ($urandom_range(0, 3) != 0) ? m_hist : int'($urandom_range(0, (1 << HIST_W) - 1));
      step(la, ($urandom_range(0, 3) != 0), ua, uh, $urandom_range(0, 1) == 1, "R6");
    end

    // R10: (1,1) configuration, slot 0
    @(negedge clk);
    a11_lkp = '0; a11_upd = '0; a11_hin = 0; a11_t = 1; a11_v = 1;
    @(negedge clk);
    a11_v = 0; #1;
    chk(a11_hout == 1'b1, "R10", int'(a11_hout), 1);
    chk(a11_pred == 1'b0, "R10", int'(a11_pred), 0);
    a11_hin = 1; a11_t = 0; a11_v = 1;
    @(negedge clk);
    a11_v = 0; #1;
    chk(a11_hout == 1'b0, "R10", int'(a11_hout), 0);
    chk(a11_pred == 1'b1, "R10", int'(a11_pred), 1);
    a11_lkp = 16'h0004; #1;
    chk(a11_pred == 1'b1, "R10", int'(a11_pred), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule